// File: doc/BRIEF.md
# Configurable SPI Master Frame Engine

This block is the serial side of an SPI master. It takes characters from a transmit queue through a valid/ready pop interface. It shifts each character out on the data-out line while it shifts a character in from the data-in line. It then pushes every received character to a receive queue as a one-cycle strobe. It drives an active-low chip enable and the serial clock. Clock polarity, clock phase and bit order are chosen per frame. Two 2-bit fields stretch the gap between chip-enable assertion and the first clock edge, and the gap between the last clock edge and chip-enable release.

Timing is paced by an external `tick` strobe. Each tick is one half period of the serial clock. Every change on chip enable, serial clock and data-out happens on a tick. A frame opens when transmit data is offered on a tick. If the queue still offers data when the current character ends, the next character follows at once with chip enable held low. If the queue is empty but `rx_cont` is high, a receive-only character follows: zeros are shifted out and the incoming character is still delivered. Otherwise the frame closes after the hold gap.

Top module: `spi_frame_master`

## Requirements
- R1: After synchronous reset, with no transmit data offered: `ce_n` is 1, `sclk` equals `cpol`, and `rx_valid` and `tx_ready` are 0.
- R2: `ce_n` falls exactly once per frame and stays low until all characters of the frame are done. `sclk` is at the `cpol` level when `ce_n` rises, and never toggles in the same cycle that `ce_n` rises.
- R3: With `cpha`=0, the first `sclk` edge follows the fall of `ce_n` by 2+2*`setup_ext` ticks.
- R4: With `cpha`=1, the first `sclk` edge follows the fall of `ce_n` by 1+2*`setup_ext` ticks.
- R5: With `cpha`=0, `ce_n` rises 1+2*`hold_ext` ticks after the last `sclk` edge.
- R6: With `cpha`=1, `ce_n` rises 2+2*`hold_ext` ticks after the last `sclk` edge.
- R7: Sampling and launching use opposite edges. `miso` is sampled on the rising edge when `cpha`==`cpol` and on the falling edge otherwise. `mosi` changes only on the opposite edge, or on the `ce_n` fall when `cpha`=0. With `lsb_first`=0 the most significant bit travels first.
- R8: With `lsb_first`=1, bit 0 of each character is sent and received first, in both directions.
- R9: Within a frame, successive `sclk` edges are exactly one tick apart, including across character boundaries. Each character takes 2*CHAR_W edges.
- R10: A character started because `rx_cont`=1 while `tx_valid`=0 shifts out all zeros, and its received character is still delivered.
- R11: Every character produces exactly one one-cycle `rx_valid` pulse, in the cycle after its last `sclk` edge. `rx_data` holds the bits sampled from `miso`.
- R12: `ce_n`, `sclk` and `mosi` change only in the cycle after a cycle with `tick`=1.
- R13: `tx_ready` is high only together with `tx_valid`, once per transmitted character.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Half-period strobe of the serial clock |
| cpol | input | 1 | Idle level of `sclk` |
| cpha | input | 1 | 0: sample on leading edge; 1: launch on leading edge |
| lsb_first | input | 1 | 1: bit 0 first; 0: top bit first |
| setup_ext | input | 2 | Extra whole periods before the first edge |
| hold_ext | input | 2 | Extra whole periods after the last edge |
| rx_cont | input | 1 | Continue with a receive-only character when no transmit data is offered |
| tx_valid | input | 1 | Transmit queue offers a character |
| tx_ready | output | 1 | Character on `tx_data` is taken this cycle |
| tx_data | input | CHAR_W | Transmit character |
| rx_valid | output | 1 | One-cycle strobe: received character on `rx_data` |
| rx_data | output | CHAR_W | Received character |
| ce_n | output | 1 | Active-low chip enable |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |

## Verification
The bench builds the block with CHAR_W=6 and a tick every third clock. A 6-bit character gives 12 edges, so the edge counter has to wrap at a value that is not a power of two. Every gap must come out as an exact multiple of three clocks, and this exposes off-by-one errors in the setup and hold counts for every `setup_ext`/`hold_ext` value. A slave model drives `miso` only on launch edges and captures `mosi` only on sample edges. In all four polarity/phase modes, both bit orders and mixed transmit/receive-only frames, any misplaced edge role, bit order or character boundary therefore corrupts the data.

// File: rtl/spi_fm_pkg.sv
package spi_fm_pkg;

    localparam int GAP_W = 4;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SETUP,
        ST_SHIFT,
        ST_HOLD
    } fm_state_e;

    typedef struct packed {
        logic       cpol;
        logic       cpha;
        logic       lsb_first;
        logic [1:0] setup_ext;
        logic [1:0] hold_ext;
    } fm_cfg_t;

    // Reload value of the gap timer (ticks minus one) before the first edge.
    function automatic logic [GAP_W-1:0] setup_reload(input logic cpha, input logic [1:0] ext);
        return {1'b0, ext, 1'b0} + {3'b000, ~cpha};
    endfunction

    // Reload value of the gap timer (ticks minus one) after the last edge.
    function automatic logic [GAP_W-1:0] hold_reload(input logic cpha, input logic [1:0] ext);
        return {1'b0, ext, 1'b0} + {3'b000, cpha};
    endfunction

endpackage

// File: rtl/spi_fm_gap_timer.sv
module spi_fm_gap_timer
    import spi_fm_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             load,
    input  logic [GAP_W-1:0] load_val,
    output logic             expired
);

    logic [GAP_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (tick && (cnt_q != '0)) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q == '0);

endmodule

// File: rtl/spi_fm_tx_launcher.sv
module spi_fm_tx_launcher #(
    parameter int CHAR_W = 8,
    parameter int IW     = $clog2(CHAR_W)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              lsb,
    input  logic              load,
    input  logic              load_drive,
    input  logic [CHAR_W-1:0] load_data,
    input  logic              launch,
    input  logic [IW-1:0]     launch_idx,
    output logic              mosi
);

    localparam logic [IW-1:0] LAST_IDX = IW'(CHAR_W - 1);

    logic [CHAR_W-1:0] txd_q;
    logic              mosi_q;
    logic [IW-1:0]     pos;
    logic              first_new;

    always_comb begin
        pos       = lsb ? launch_idx : (LAST_IDX - launch_idx);
        first_new = lsb ? load_data[0] : load_data[CHAR_W-1];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            txd_q  <= '0;
            mosi_q <= 1'b0;
        end else begin
            if (load) begin
                txd_q <= load_data;
            end
            if (load && load_drive) begin
                mosi_q <= first_new;
            end else if (launch) begin
                mosi_q <= txd_q[pos];
            end
        end
    end

    assign mosi = mosi_q;

endmodule

// File: rtl/spi_fm_rx_assembler.sv
module spi_fm_rx_assembler #(
    parameter int CHAR_W = 8,
    parameter int IW     = $clog2(CHAR_W)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              lsb,
    input  logic              sample,
    input  logic [IW-1:0]     sample_idx,
    input  logic              miso,
    input  logic              finish,
    output logic              rx_valid,
    output logic [CHAR_W-1:0] rx_data
);

    localparam logic [IW-1:0] LAST_IDX = IW'(CHAR_W - 1);

    logic [CHAR_W-1:0] acc_q;
    logic [CHAR_W-1:0] acc_next;
    logic [IW-1:0]     pos;
    logic              valid_q;
    logic [CHAR_W-1:0] data_q;

    always_comb begin
        pos      = lsb ? sample_idx : (LAST_IDX - sample_idx);
        acc_next = acc_q;
        if (sample) begin
            acc_next[pos] = miso;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q   <= '0;
            valid_q <= 1'b0;
            data_q  <= '0;
        end else begin
            acc_q   <= acc_next;
            valid_q <= finish;
            if (finish) begin
                data_q <= acc_next;
            end
        end
    end

    assign rx_valid = valid_q;
    assign rx_data  = data_q;

    AST_RX_SINGLE_PULSE: assert property (@(posedge clk) disable iff (rst)
        rx_valid |=> !rx_valid) else $error("rx strobe longer than one cycle"); // R11

endmodule

// File: rtl/spi_frame_master.sv
module spi_frame_master
    import spi_fm_pkg::*;
#(
    parameter int CHAR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              cpol,
    input  logic              cpha,
    input  logic              lsb_first,
    input  logic [1:0]        setup_ext,
    input  logic [1:0]        hold_ext,
    input  logic              rx_cont,
    input  logic              tx_valid,
    output logic              tx_ready,
    input  logic [CHAR_W-1:0] tx_data,
    output logic              rx_valid,
    output logic [CHAR_W-1:0] rx_data,
    output logic              ce_n,
    output logic              sclk,
    output logic              mosi,
    input  logic              miso
);

    localparam int EDGES = 2 * CHAR_W;
    localparam int EW    = $clog2(EDGES);
    localparam int IW    = EW - 1;
    localparam logic [EW-1:0] LAST_EDGE = EW'(EDGES - 1);

    generate
        if (CHAR_W < 4 || CHAR_W > 16) begin : g_bad_width
            $error("CHAR_W must lie between 4 and 16");
        end
    endgenerate

    fm_state_e        state_q;
    fm_cfg_t          cfg_q;
    logic [EW-1:0]    edge_q;
    logic             ce_n_q;
    logic             sclk_q;

    logic             start;
    logic             do_edge;
    logic             last_edge;
    logic             more;
    logic             end_char;
    logic             ld;
    logic [CHAR_W-1:0] ld_data;
    logic             ld_drive;
    logic             ld_lsb;
    logic             sample_stb;
    logic             launch_stb;
    logic [EW-1:0]    edge_inc;
    logic [IW-1:0]    launch_idx;
    logic             gap_load;
    logic [GAP_W-1:0] gap_val;
    logic             gap_expired;

    always_comb begin
        start      = (state_q == ST_IDLE) && tick && tx_valid;
        do_edge    = tick && ((state_q == ST_SHIFT) ||
                              ((state_q == ST_SETUP) && gap_expired));
        last_edge  = (edge_q == LAST_EDGE);
        more       = tx_valid || rx_cont;
        end_char   = do_edge && last_edge;
        tx_ready   = start || (end_char && tx_valid);
        ld         = start || (end_char && more);
        ld_data    = tx_valid ? tx_data : '0;
        ld_drive   = start ? ~cpha : ~cfg_q.cpha;
        ld_lsb     = start ? lsb_first : cfg_q.lsb_first;
        sample_stb = do_edge && (edge_q[0] == cfg_q.cpha);
        launch_stb = do_edge && (edge_q[0] != cfg_q.cpha) && !last_edge;
        edge_inc   = edge_q + 1'b1;
        launch_idx = cfg_q.cpha ? edge_q[EW-1:1] : edge_inc[EW-1:1];
        gap_load   = start || (end_char && !more);
        gap_val    = start ? setup_reload(cpha, setup_ext)
                           : hold_reload(cfg_q.cpha, cfg_q.hold_ext);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            cfg_q   <= '0;
            edge_q  <= '0;
            ce_n_q  <= 1'b1;
            sclk_q  <= cpol;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    sclk_q <= cpol;
                    if (start) begin
                        ce_n_q  <= 1'b0;
                        cfg_q   <= fm_cfg_t'({cpol, cpha, lsb_first, setup_ext, hold_ext});
                        edge_q  <= '0;
                        state_q <= ST_SETUP;
                    end
                end
                ST_SETUP, ST_SHIFT: begin
                    if (do_edge) begin
                        sclk_q  <= ~sclk_q;
                        edge_q  <= last_edge ? '0 : edge_inc;
                        state_q <= (end_char && !more) ? ST_HOLD : ST_SHIFT;
                    end
                end
                ST_HOLD: begin
                    if (tick && gap_expired) begin
                        ce_n_q  <= 1'b1;
                        state_q <= ST_IDLE;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign ce_n = ce_n_q;
    assign sclk = sclk_q;

    spi_fm_gap_timer u_gap (
        .clk      (clk),
        .rst      (rst),
        .tick     (tick),
        .load     (gap_load),
        .load_val (gap_val),
        .expired  (gap_expired)
    );

    spi_fm_tx_launcher #(.CHAR_W(CHAR_W), .IW(IW)) u_tx (
        .clk        (clk),
        .rst        (rst),
        .lsb        (ld_lsb),
        .load       (ld),
        .load_drive (ld_drive),
        .load_data  (ld_data),
        .launch     (launch_stb),
        .launch_idx (launch_idx),
        .mosi       (mosi)
    );

    spi_fm_rx_assembler #(.CHAR_W(CHAR_W), .IW(IW)) u_rx (
        .clk        (clk),
        .rst        (rst),
        .lsb        (cfg_q.lsb_first),
        .sample     (sample_stb),
        .sample_idx (edge_q[EW-1:1]),
        .miso       (miso),
        .finish     (end_char),
        .rx_valid   (rx_valid),
        .rx_data    (rx_data)
    );

    AST_SCLK_ON_TICK: assert property (@(posedge clk) disable iff (rst)
        (!$stable(sclk) && !ce_n) |-> $past(tick)) else $error("sclk moved without tick"); // R12
    AST_CE_ON_TICK: assert property (@(posedge clk) disable iff (rst)
        !$stable(ce_n) |-> $past(tick)) else $error("ce_n moved without tick"); // R12
    AST_MOSI_ON_TICK: assert property (@(posedge clk) disable iff (rst)
        !$stable(mosi) |-> $past(tick)) else $error("mosi moved without tick"); // R7
    AST_NO_EDGE_AT_RELEASE: assert property (@(posedge clk) disable iff (rst)
        $rose(ce_n) |-> $stable(sclk)) else $error("sclk edge at chip-enable release"); // R2
    AST_POP_WITH_VALID: assert property (@(posedge clk) disable iff (rst)
        tx_ready |-> (tx_valid && !ce_n) || (tx_valid && $past(ce_n))) else $error("pop without data"); // R13

endmodule

// File: tb/tb_spi_frame_master.sv
module tb_spi_frame_master;

    localparam int W    = 6;
    localparam int TDIV = 3;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic         rst = 1'b1;
    logic         tick = 1'b0;
    logic         cpol = 1'b0, cpha = 1'b0, lsb_first = 1'b0;
    logic [1:0]   setup_ext = 2'd0, hold_ext = 2'd0;
    logic         rx_cont = 1'b0;
    logic         tx_valid = 1'b0;
    logic         tx_ready;
    logic [W-1:0] tx_data = '0;
    logic         rx_valid;
    logic [W-1:0] rx_data;
    logic         ce_n, sclk, mosi;
    logic         miso = 1'b0;

    spi_frame_master #(.CHAR_W(W)) dut (
        .clk(clk), .rst(rst), .tick(tick), .cpol(cpol), .cpha(cpha),
        .lsb_first(lsb_first), .setup_ext(setup_ext), .hold_ext(hold_ext),
        .rx_cont(rx_cont), .tx_valid(tx_valid), .tx_ready(tx_ready),
        .tx_data(tx_data), .rx_valid(rx_valid), .rx_data(rx_data),
        .ce_n(ce_n), .sclk(sclk), .mosi(mosi), .miso(miso)
    );

    int checks = 0;
    int errors = 0;

    logic [W-1:0] tw [0:15];
    logic [W-1:0] sw [0:15];
    logic [W-1:0] rxw [0:15];
    logic         cap_bits [0:255];
    int n_tx = 0, n_ro = 0, total = 0;
    int tx_idx = 0, rx_seen = 0, n_pop = 0;
    bit pop_pending = 0;
    int tcnt = 0;

    int cyc = 0;
    int drv_n = 0, cap_n = 0, n_edges = 0, bad_gap = 0, n_fall = 0;
    int t_fall = 0, t_first = 0, t_last = 0, t_rise = 0;
    logic prev_sclk = 1'b0, prev_ce = 1'b1;

    function automatic logic sbit(int j);
        logic [W-1:0] wd;
        int i;
        wd = sw[(j / W) % 16];
        i  = j % W;
        return lsb_first ? wd[i] : wd[W-1-i];
    endfunction

    // Slave model: launches miso on launch edges, captures mosi on sample edges.
    always @(negedge clk) begin
        cyc = cyc + 1;
        if (!rst) begin
            if (prev_ce && !ce_n) begin
                n_fall++;
                t_fall  = cyc;
                drv_n   = 0;
                cap_n   = 0;
                n_edges = 0;
                bad_gap = 0;
                if (!cpha) begin
                    miso  = sbit(0);
                    drv_n = 1;
                end
            end
            if (!prev_ce && ce_n) t_rise = cyc;
            if ((sclk != prev_sclk) && !ce_n) begin
                if (n_edges == 0) t_first = cyc;
                else if (cyc - t_last != TDIV) bad_gap++;
                t_last = cyc;
                n_edges++;
                if ((prev_sclk == cpol) == !cpha) begin
                    if (cap_n < 256) cap_bits[cap_n] = mosi;
                    cap_n++;
                end else begin
                    miso = sbit(drv_n);
                    drv_n++;
                end
            end
        end
        prev_sclk = sclk;
        prev_ce   = ce_n;
    end

    task automatic check(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
        if (pop_pending) begin
            tx_idx++;
            n_pop++;
        end
        if (rx_valid) begin
            if (rx_seen < 16) rxw[rx_seen] = rx_data;
            rx_seen++;
        end
        tick     = (tcnt == 0);
        tcnt     = (tcnt + 1) % TDIV;
        tx_valid = (tx_idx < n_tx);
        tx_data  = tw[tx_idx % 16];
        rx_cont  = (rx_seen + 1 < total);
        #1;
        pop_pending = tx_valid && tx_ready;
    endtask

    task automatic run_frame(bit cp, bit ch, bit lb, int su, int ho, int ntx, int nro);
        int s_exp, h_exp, guard;
        logic [W-1:0] got, exp_w;
        string req;
        cpol = cp; cpha = ch; lsb_first = lb;
        setup_ext = 2'(su); hold_ext = 2'(ho);
        n_tx = 0; total = 0; tx_idx = 0; rx_seen = 0; n_pop = 0; n_fall = 0;
        for (int i = 0; i < 16; i++) begin
            tw[i] = W'($urandom);
            sw[i] = W'($urandom);
        end
        repeat (4) step();
        n_ro = nro; total = ntx + nro; n_tx = ntx;
        guard = 0;
        while (!(rx_seen == total && ce_n == 1'b1 && n_fall > 0) && guard < 5000) begin
            step();
            guard++;
        end
        repeat (2) step();

        s_exp = (ch ? 1 : 2) + 2 * su;
        h_exp = (ch ? 2 : 1) + 2 * ho;
        check(t_first - t_fall == s_exp * TDIV, ch ? "R4 setup gap" : "R3 setup gap",
              t_first - t_fall, s_exp * TDIV);
        check(t_rise - t_last == h_exp * TDIV, ch ? "R6 hold gap" : "R5 hold gap",
              t_rise - t_last, h_exp * TDIV);
        check(n_fall == 1, "R2 one chip-enable window", n_fall, 1);
        check(sclk == cp && ce_n == 1'b1, "R2 idle level after frame", int'(sclk), int'(cp));
        check(n_edges == 2 * W * total, "R9 edge count", n_edges, 2 * W * total);
        check(bad_gap == 0, "R9 edge spacing", bad_gap, 0);
        check((t_rise - t_fall) % TDIV == 0, "R12 tick alignment", (t_rise - t_fall) % TDIV, 0);
        check(n_pop == ntx, "R13 pops", n_pop, ntx);
        check(rx_seen == total, "R11 rx strobes", rx_seen, total);
        for (int k = 0; k < total && k < 6; k++) begin
            got = '0;
            for (int i = 0; i < W; i++) begin
                if (lb) got[i] = cap_bits[k*W + i];
                else    got[W-1-i] = cap_bits[k*W + i];
            end
            exp_w = (k < ntx) ? tw[k] : '0;
            req = (k >= ntx) ? "R10 receive-only zeros" : (lb ? "R8 lsb-first out" : "R7 msb-first out");
            check(got == exp_w, req, int'(got), int'(exp_w));
            check(rxw[k] == sw[k], lb ? "R8 R11 rx data" : "R7 R11 rx data", int'(rxw[k]), int'(sw[k]));
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual 1 expected 0");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        repeat (5) step();
        rst = 1'b0;
        repeat (3) step();
        // R1 reset state
        check(ce_n == 1'b1, "R1 ce_n", int'(ce_n), 1);
        check(sclk == cpol, "R1 sclk", int'(sclk), int'(cpol));
        check(rx_valid == 1'b0, "R1 rx_valid", int'(rx_valid), 0);
        check(tx_ready == 1'b0, "R1 tx_ready", int'(tx_ready), 0);

        // directed corners: every mode, gap extremes, back-to-back, receive-only
        run_frame(0, 0, 0, 0, 0, 1, 0);
        run_frame(0, 1, 0, 0, 0, 1, 0);
        run_frame(1, 0, 1, 3, 3, 1, 0);
        run_frame(1, 1, 1, 3, 3, 1, 0);
        run_frame(0, 0, 1, 1, 2, 3, 0);
        run_frame(1, 1, 0, 2, 1, 3, 1);
        run_frame(0, 1, 1, 0, 3, 1, 3);
        run_frame(1, 0, 0, 3, 0, 2, 2);

        for (int f = 0; f < 24; f++) begin
            run_frame(1'($urandom), 1'($urandom), 1'($urandom),
                      int'($urandom % 4), int'($urandom % 4),
                      1 + int'($urandom % 3), int'($urandom % 3));
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule